// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Engine

This block turns host commands into the waveforms of a single-wire open-drain bus. A command either starts a reset cycle or starts one or eight data slots. In a reset cycle the engine holds the line low, releases it, and then looks at the line twice. The first look detects a shorted line. The second look detects a presence reply from a target. In a data slot the engine pulls the line low for a short time to send a one, or for a long time to send a zero. A read is a write-one slot in which the engine samples the line at a set point. The engine drives only a pulldown enable. It sees the bus through a digital copy of the line that has already been thresholded.

Every phase length comes from a timing word. There is one word for standard speed and one for overdrive speed, and the speed is chosen when a command starts. All lengths are counted in pulses of a tick input, which sets the timebase. A slot always lasts the zero-low time plus the recovery time, whatever the bit value. Byte commands run eight slots back to back, least significant bit first. A byte command raises one done pulse after the last slot.

Top module: `ow_slot_engine`

## Requirements
- R1: After reset, and at all times when `busy` is low, `line_pd` is low. The reset state is `busy`=0, `done`=0, `presence`=0, `short_flag`=0 and `rx_data`=0.
- R2: Each timing word packs eight TCW-bit fields. Field k sits at bits [k*TCW +: TCW], with k=7 reset-low, 6 reset-high, 5 presence sample, 4 short sample, 3 one-low, 2 read sample, 1 zero-low and 0 recovery. `overdrive` is sampled when a command is accepted and picks `t_od` (1) or `t_std` (0). Changing `overdrive` or either timing word while a command runs has no effect on that command. All fields must be nonzero, and the short sample must come before the presence sample.
- R3: Opcode 2'b00 is a reset cycle. `line_pd` is high for reset-low ticks and then low for reset-high ticks. `done` pulses in the cycle after the last tick, so with a tick on every cycle it comes reset-low + reset-high + 1 cycles after the accepting edge.
- R4: If the line reads low at short-sample ticks after release, `short_flag` is set and `presence` reads 0 for that reset cycle.
- R5: If the line reads low at presence-sample ticks after release and no short was seen, `presence` is 1. Otherwise it is 0. Both flags are cleared when a new reset cycle starts.
- R6: A data slot lasts zero-low + recovery ticks. `line_pd` is high for one-low ticks when the bit is 1 and for zero-low ticks when the bit is 0, starting at the first tick of the slot.
- R7: In every slot the line is sampled at read-sample ticks after the slot's falling edge, and the result is stored as that slot's bit of `rx_data`.
- R8: Opcode 2'b10 runs eight slots with no gap between them. Slot i sends `cmd_data[i]` (bit 0 first) and fills `rx_data[i]`. A single `done` pulse comes 8*(zero-low+recovery)+1 cycles after acceptance.
- R9: Opcode 2'b01 runs one slot that sends `cmd_data[0]`. It leaves `rx_data` = {7'b0, sampled bit}, and `done` comes zero-low+recovery+1 cycles after acceptance.
- R10: A command is accepted only when `cmd_valid` is high and `busy` is low. `busy` rises in the next cycle. Commands offered while `busy` is high are ignored, and opcode 2'b11 is never accepted.
- R11: The phase counters advance only on cycles where `tick` is high. With a tick every second cycle, every phase length doubles, give or take one cycle of alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable; one pulse is one timing unit |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 00 reset cycle, 01 single slot, 10 byte, 11 reserved |
| cmd_data | input | 8 | Bits to send; 1s for read slots |
| overdrive | input | 1 | Speed select, sampled at acceptance |
| t_std | input | 8*TCW | Standard-speed timing word |
| t_od | input | 8*TCW | Overdrive timing word |
| line_in | input | 1 | Thresholded copy of the bus line |
| line_pd | output | 1 | Open-drain pulldown enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command end |
| presence | output | 1 | Presence seen in the last reset cycle |
| short_flag | output | 1 | Short seen in the last reset cycle |
| rx_data | output | 8 | Sampled slot bits |

## Verification
If the phase counter is wrong or the opcode is decoded wrongly, the pulldown pulse is too long or too short. The monitor that measures every pulldown pulse in cycles sees this at the end of the first pulse. A wrong slot length or bit index shows up either in the `done` latency or in a byte read back with its bits shifted or swapped, once the eighth slot has ended. A sample taken at the wrong point, or a bad flag update, changes `rx_data`, `presence` or `short_flag` at the next `done`. The slave model sets its reply windows so that an off-by-several sample point reads the wrong level. Sweeping every byte value at overdrive speed covers every bit position with both values, and a few patterns do the same at standard speed.

// File: rtl/ow_pkg.sv
package ow_pkg;
    parameter int unsigned TCW = 10;
    localparam int unsigned NPH = 8;
    localparam int unsigned SLW = TCW + 1;
    localparam int unsigned BITS = 8;
    localparam int unsigned IDW = $clog2(BITS);

    typedef struct packed {
        logic [TCW-1:0] rst_lo;
        logic [TCW-1:0] rst_hi;
        logic [TCW-1:0] pres_smp;
        logic [TCW-1:0] short_smp;
        logic [TCW-1:0] one_lo;
        logic [TCW-1:0] rd_smp;
        logic [TCW-1:0] zero_lo;
        logic [TCW-1:0] recov;
    } ow_times_t;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_BIT   = 2'b01,
        OP_BYTE  = 2'b10,
        OP_NONE  = 2'b11
    } ow_op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RLOW, ST_RHIGH, ST_SLOT
    } ow_state_e;

    typedef struct packed {
        logic           smp_short;
        logic           smp_pres;
        logic           smp_bit;
        logic [IDW-1:0] idx;
    } ow_strobe_t;

    function automatic logic [SLW-1:0] slot_len(ow_times_t t);
        return SLW'(t.zero_lo) + SLW'(t.recov);
    endfunction
endpackage

// File: rtl/ow_time_latch.sv
module ow_time_latch
    import ow_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 od,
    input  logic [NPH*TCW-1:0]   t_std,
    input  logic [NPH*TCW-1:0]   t_od,
    output ow_times_t            cur
);
    always_ff @(posedge clk) begin
        if (rst)       cur <= '0;
        else if (load) cur <= od ? ow_times_t'(t_od) : ow_times_t'(t_std);
    end
endmodule

// File: rtl/ow_phase_ctrl.sv
module ow_phase_ctrl
    import ow_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            start,
    input  ow_op_e          op,
    input  logic [BITS-1:0] data,
    input  ow_times_t       tim,
    output logic            busy,
    output logic            pd,
    output logic            done,
    output ow_strobe_t      stb
);
    ow_state_e       state;
    logic [SLW-1:0]  cnt;
    logic [IDW-1:0]  idx;
    logic            byte_mode;
    logic [BITS-1:0] wdata;
    logic [SLW-1:0]  nxt;
    logic [SLW-1:0]  low_len;

    assign nxt     = cnt + SLW'(1);
    assign low_len = wdata[idx] ? SLW'(tim.one_lo) : SLW'(tim.zero_lo);
    assign busy    = (state != ST_IDLE);
    assign pd      = (state == ST_RLOW) || ((state == ST_SLOT) && (cnt < low_len));

    always_comb begin
        stb.smp_short = (state == ST_RHIGH) && tick && (cnt == SLW'(tim.short_smp));
        stb.smp_pres  = (state == ST_RHIGH) && tick && (cnt == SLW'(tim.pres_smp));
        stb.smp_bit   = (state == ST_SLOT)  && tick && (cnt == SLW'(tim.rd_smp));
        stb.idx       = idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            byte_mode <= 1'b0;
            wdata     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state     <= (op == OP_RESET) ? ST_RLOW : ST_SLOT;
                cnt       <= '0;
                idx       <= '0;
                byte_mode <= (op == OP_BYTE);
                wdata     <= data;
            end else if (tick) begin
                unique case (state)
                    ST_RLOW: begin
                        if (nxt >= SLW'(tim.rst_lo)) begin
                            state <= ST_RHIGH;
                            cnt   <= '0;
                        end else cnt <= nxt;
                    end
                    ST_RHIGH: begin
                        if (nxt >= SLW'(tim.rst_hi)) begin
                            state <= ST_IDLE;
                            cnt   <= '0;
                            done  <= 1'b1;
                        end else cnt <= nxt;
                    end
                    ST_SLOT: begin
                        if (nxt >= slot_len(tim)) begin
                            cnt <= '0;
                            if (byte_mode && (idx != IDW'(BITS-1))) begin
                                idx <= idx + IDW'(1);
                            end else begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end
                        end else cnt <= nxt;
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    AST_TICK_GATES_COUNT: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> ($stable(cnt) && $stable(idx))); // R11
    AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !$past(done))); // R8
    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT && slot_len(tim) != '0) |-> (cnt < slot_len(tim))); // R6
endmodule

// File: rtl/ow_sampler.sv
module ow_sampler
    import ow_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            start_reset,
    input  logic            line_in,
    input  ow_strobe_t      stb,
    output logic            presence,
    output logic            short_flag,
    output logic [BITS-1:0] rx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            presence   <= 1'b0;
            short_flag <= 1'b0;
            rx         <= '0;
        end else if (start) begin
            rx <= '0;
            if (start_reset) begin
                presence   <= 1'b0;
                short_flag <= 1'b0;
            end
        end else begin
            if (stb.smp_short && !line_in) begin
                short_flag <= 1'b1;
                presence   <= 1'b0;
            end else if (stb.smp_pres) begin
                presence <= !line_in && !short_flag;
            end
            if (stb.smp_bit) rx[stb.idx] <= line_in;
        end
    end

    AST_SHORT_KILLS_PRES: assert property (@(posedge clk) disable iff (rst)
        short_flag |-> !presence); // R4
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
    import ow_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [7:0]           cmd_data,
    input  logic                 overdrive,
    input  logic [NPH*TCW-1:0]   t_std,
    input  logic [NPH*TCW-1:0]   t_od,
    input  logic                 line_in,
    output logic                 line_pd,
    output logic                 busy,
    output logic                 done,
    output logic                 presence,
    output logic                 short_flag,
    output logic [7:0]           rx_data
);
    ow_times_t  tim;
    ow_strobe_t stb;
    ow_op_e     op;
    logic       start;

    assign op    = ow_op_e'(cmd_op);
    assign start = cmd_valid && !busy && (op != OP_NONE);

    ow_time_latch u_time (
        .clk(clk), .rst(rst), .load(start), .od(overdrive),
        .t_std(t_std), .t_od(t_od), .cur(tim)
    );

    ow_phase_ctrl u_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .op(op),
        .data(cmd_data), .tim(tim), .busy(busy), .pd(line_pd),
        .done(done), .stb(stb)
    );

    ow_sampler u_smp (
        .clk(clk), .rst(rst), .start(start), .start_reset(op == OP_RESET),
        .line_in(line_in), .stb(stb), .presence(presence),
        .short_flag(short_flag), .rx(rx_data)
    );

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_pd); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op != 2'b11) |=> busy); // R10
    AST_TIMING_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(tim)); // R2
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(stb.smp_bit || stb.smp_pres || stb.smp_short)); // R7
endmodule

// File: tb/tb_ow_slot_engine.sv
module tb_ow_slot_engine;
    import ow_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_data = 8'h00;
    logic overdrive = 1'b0;
    logic [NPH*TCW-1:0] t_std, t_od;
    logic line_in, line_pd, busy, done, presence, short_flag;
    logic [7:0] rx_data;
    logic slave_pd = 1'b0;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int tdiv = 1;
    int ecount = 0, slotidx = -1;
    logic prev_pd = 1'b0;
    int pw [0:15];
    int npw = 0;
    int smode = 0;
    int pwin_lo = 0, pwin_hi = 0, hold = 0;
    logic [7:0] spat = 8'h00;

    // timing sets: rstl rsth msp msi w1l msr w0l rec
    localparam int S_RL = 48, S_RH = 48, S_MP = 10, S_MI = 2, S_W1 = 6, S_MR = 9, S_W0 = 60, S_RC = 5;
    localparam int O_RL = 12, O_RH = 14, O_MP = 5,  O_MI = 1, O_W1 = 1, O_MR = 2, O_W0 = 8,  O_RC = 2;

    function automatic logic [NPH*TCW-1:0] pack_t(int rl, int rh, int mp, int mi, int w1, int mr, int w0, int rc);
        return {TCW'(rl), TCW'(rh), TCW'(mp), TCW'(mi), TCW'(w1), TCW'(mr), TCW'(w0), TCW'(rc)};
    endfunction

    assign line_in = !(line_pd || slave_pd);

    ow_slot_engine dut (
        .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .overdrive(overdrive), .t_std(t_std), .t_od(t_od),
        .line_in(line_in), .line_pd(line_pd), .busy(busy), .done(done),
        .presence(presence), .short_flag(short_flag), .rx_data(rx_data)
    );

    always #10 clk = ~clk;

    // monitor and slave model, all on the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        tick = (tdiv <= 1) ? 1'b1 : ((cyc % tdiv) == 0);
        if (line_pd && !prev_pd) begin
            ecount = 0;
            slotidx = slotidx + 1;
        end else begin
            ecount = ecount + 1;
        end
        if (!line_pd && prev_pd && npw < 16) begin
            pw[npw] = ecount;
            npw = npw + 1;
        end
        prev_pd = line_pd;
        case (smode)
            1: slave_pd = (ecount >= pwin_lo) && (ecount < pwin_hi);
            2: slave_pd = 1'b1;
            3: slave_pd = (slotidx >= 0) && !spat[slotidx[2:0]] && (ecount < hold);
            default: slave_pd = 1'b0;
        endcase
        if (cyc > 190000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 190000)", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // issue a command, return latency in cycles from the accepting edge to done
    // optional interference: at cycle 'poke' offer a reset and flip overdrive
    task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input logic od,
                           input int poke, output int lat);
        @(negedge clk);
        npw = 0;
        slotidx = -1;
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; overdrive = od;
        @(posedge clk);
        lat = 0;
        forever begin
            @(negedge clk);
            lat = lat + 1;
            cmd_valid = 1'b0;
            if (poke > 0 && lat == poke) begin
                cmd_valid = 1'b1; cmd_op = 2'b00; overdrive = !od;
            end
            if (done) break;
            if (lat > 5000) begin
                chk(1'b0, "watchdog", lat, 0);
                break;
            end
        end
        cmd_valid = 1'b0;
        overdrive = od;
    endtask

    // check every pulldown pulse of a slot command against the sent bits
    task automatic chk_slots(input logic [7:0] d, input int nb, input int w1, input int w0, input string req);
        logic ok;
        int bad_at;
        ok = (npw == nb);
        bad_at = -1;
        for (int i = 0; i < nb; i++) begin
            if (pw[i] != (d[i] ? w1 : w0)) begin
                ok = 1'b0;
                if (bad_at < 0) bad_at = i;
            end
        end
        if (bad_at < 0) chk(ok, req, npw, nb);
        else chk(ok, req, pw[bad_at], d[bad_at] ? w1 : w0);
    endtask

    initial begin
        int lat;
        t_std = pack_t(S_RL, S_RH, S_MP, S_MI, S_W1, S_MR, S_W0, S_RC);
        t_od  = pack_t(O_RL, O_RH, O_MP, O_MI, O_W1, O_MR, O_W0, O_RC);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!line_pd && !busy && !done, "R1 idle outputs", {line_pd, busy, done}, 0);
        chk(!presence && !short_flag && rx_data == 8'h00, "R1 flags", {presence, short_flag, rx_data}, 0);

        // R3 R5 reset cycle with presence, standard speed
        smode = 1; pwin_lo = S_RL + 6; pwin_hi = S_RL + 20;
        run_cmd(2'b00, 8'h00, 1'b0, 0, lat);
        chk(lat == S_RL + S_RH + 1, "R3 std reset latency", lat, S_RL + S_RH + 1);
        chk(npw >= 1 && pw[0] == S_RL, "R3 std reset low", pw[0], S_RL);
        chk(presence && !short_flag, "R5 std presence", {presence, short_flag}, 2);

        // R3 R5 overdrive reset, presence
        pwin_lo = O_RL + 3; pwin_hi = O_RL + 8;
        run_cmd(2'b00, 8'h00, 1'b1, 0, lat);
        chk(lat == O_RL + O_RH + 1, "R3 od reset latency", lat, O_RL + O_RH + 1);
        chk(pw[0] == O_RL, "R3 od reset low", pw[0], O_RL);
        chk(presence && !short_flag, "R5 od presence", {presence, short_flag}, 2);

        // R5 no slave: no presence, window that ends just before the sample point
        smode = 0;
        run_cmd(2'b00, 8'h00, 1'b1, 0, lat);
        chk(!presence && !short_flag, "R5 od no slave", {presence, short_flag}, 0);
        smode = 1; pwin_lo = S_RL + 4; pwin_hi = S_RL + S_MP;
        run_cmd(2'b00, 8'h00, 1'b0, 0, lat);
        chk(!presence && !short_flag, "R5 std reply too early", {presence, short_flag}, 0);

        // R4 shorted line
        smode = 2;
        run_cmd(2'b00, 8'h00, 1'b0, 0, lat);
        chk(short_flag && !presence, "R4 std short", {presence, short_flag}, 1);
        run_cmd(2'b00, 8'h00, 1'b1, 0, lat);
        chk(short_flag && !presence, "R4 od short", {presence, short_flag}, 1);
        smode = 0;
        run_cmd(2'b00, 8'h00, 1'b1, 0, lat);
        chk(!short_flag && !presence, "R5 flags cleared by new reset", {presence, short_flag}, 0);

        // R9 single slots
        for (int b = 0; b < 2; b++) begin
            run_cmd(2'b01, 8'(b), 1'b1, 0, lat);
            chk(lat == O_W0 + O_RC + 1, "R9 od bit latency", lat, O_W0 + O_RC + 1);
            chk(rx_data == 8'(b), "R9 od bit loopback", rx_data, b);
            chk_slots(8'(b), 1, O_W1, O_W0, "R6 od bit pulse");
            run_cmd(2'b01, 8'(b), 1'b0, 0, lat);
            chk(lat == S_W0 + S_RC + 1, "R9 std bit latency", lat, S_W0 + S_RC + 1);
            chk(rx_data == 8'(b), "R9 std bit loopback", rx_data, b);
        end
        smode = 3; spat = 8'h00; hold = S_MR + 4;
        run_cmd(2'b01, 8'hFF, 1'b0, 0, lat);
        chk(rx_data == 8'h00, "R7 std read zero", rx_data, 0);
        smode = 0;

        // R6 R8 overdrive write sweep, all byte values
        for (int v = 0; v < 256; v++) begin
            run_cmd(2'b10, 8'(v), 1'b1, 0, lat);
            chk(lat == 8 * (O_W0 + O_RC) + 1, "R8 od byte latency", lat, 8 * (O_W0 + O_RC) + 1);
            chk(rx_data == 8'(v), "R8 od byte loopback", rx_data, v);
            chk_slots(8'(v), 8, O_W1, O_W0, "R6 od byte pulses");
        end

        // R7 R8 overdrive read sweep, slave drives every pattern
        smode = 3; hold = O_MR + 2;
        for (int v = 0; v < 256; v++) begin
            spat = 8'(v);
            run_cmd(2'b10, 8'hFF, 1'b1, 0, lat);
            chk(rx_data == 8'(v), "R7 od read byte", rx_data, v);
        end

        // R7 sample point: slave releases one tick before the sample, reads as 1
        spat = 8'h00; hold = O_MR;
        run_cmd(2'b10, 8'hFF, 1'b1, 0, lat);
        chk(rx_data == 8'hFF, "R7 od release before sample", rx_data, 255);
        hold = O_MR + 1;
        run_cmd(2'b10, 8'hFF, 1'b1, 0, lat);
        chk(rx_data == 8'h00, "R7 od held through sample", rx_data, 0);

        // R6 R7 R8 standard speed patterns
        smode = 3; hold = S_MR + 10;
        spat = 8'h3C;
        run_cmd(2'b10, 8'hFF, 1'b0, 0, lat);
        chk(rx_data == 8'h3C, "R7 std read byte", rx_data, 8'h3C);
        smode = 0;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] v;
            v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'h81;
            run_cmd(2'b10, v, 1'b0, 0, lat);
            chk(lat == 8 * (S_W0 + S_RC) + 1, "R8 std byte latency", lat, 8 * (S_W0 + S_RC) + 1);
            chk(rx_data == v, "R8 std byte loopback", rx_data, v);
            chk_slots(v, 8, S_W1, S_W0, "R6 std byte pulses");
        end

        // R10 R2 command and speed change while busy are ignored
        run_cmd(2'b10, 8'hA5, 1'b0, 20, lat);
        chk(lat == 8 * (S_W0 + S_RC) + 1, "R10 busy latency", lat, 8 * (S_W0 + S_RC) + 1);
        chk(rx_data == 8'hA5, "R10 busy data", rx_data, 8'hA5);
        chk_slots(8'hA5, 8, S_W1, S_W0, "R2 speed frozen while busy");
        @(negedge clk);
        chk(!busy, "R10 no queued command", busy, 0);

        // R10 reserved opcode
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_data = 8'h00;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!busy && !line_pd, "R10 reserved opcode", {busy, line_pd}, 0);
        @(negedge clk);
        chk(!busy, "R1 still idle", busy, 0);

        // R11 tick every second cycle
        tdiv = 2;
        run_cmd(2'b00, 8'h00, 1'b1, 0, lat);
        chk(pw[0] >= 2 * O_RL - 1 && pw[0] <= 2 * O_RL, "R11 scaled reset low", pw[0], 2 * O_RL);
        chk(lat >= 2 * (O_RL + O_RH) - 1 && lat <= 2 * (O_RL + O_RH) + 2, "R11 scaled latency", lat, 2 * (O_RL + O_RH));
        run_cmd(2'b01, 8'h00, 1'b1, 0, lat);
        chk(pw[0] >= 2 * O_W0 - 1 && pw[0] <= 2 * O_W0, "R11 scaled zero low", pw[0], 2 * O_W0);
        tdiv = 1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule